// File: doc/BRIEF.md
# Bank-Balanced Sparse Dot-Product Engine

This block forms the dot product of one pruned weight row with a dense vector. The row is cut into `N_BANKS` equal slices, and every slice keeps the same number `NNZ_PER_BANK` of nonzero weights. The vector is cut the same way into `N_BANKS` contiguous slices. Each vector slice lives in its own small memory, so on every step one element can be fetched from each slice without any contention.

On a step the caller presents one nonzero weight per bank, together with that weight's position inside its bank. The position is used as the read address of the bank's memory. All bank products are formed in parallel and summed by an adder tree. The step sums of a row are accumulated at full precision. After the row's final step, the saturated Q8.8 result is emitted with a one-cycle valid pulse. The vector is loaded beforehand, or between steps, through a single write port that uses flat vector addresses.

Top module: `bbs_dot_engine`

## Requirements
- R1: A vector write with `vec_we_i=1` at flat address `a` stores `vec_wdata_i` in bank `a / (VEC_LEN/N_BANKS)` at offset `a % (VEC_LEN/N_BANKS)`. With the defaults (12 entries, 4 banks), bank b holds addresses 3b..3b+2.
- R2: On an accepted step (`step_valid_i=1`), lane b takes its weight from `step_wgt_i[b*16 +: 16]` and its bank-internal index from `step_idx_i[b*2 +: 2]`. Lane b reads bank b at that index, and all lanes are served in the same step.
- R3: A step contributes the exact sum over all lanes of signed weight times signed vector element. Both operands are two's-complement Q8.8.
- R4: After `NNZ_PER_BANK` accepted steps of a row, `result_valid_o` is high for exactly one cycle. This happens after the third rising edge counted from the edge that accepted the row's last step. `result_o` then equals the row's sum arithmetically shifted right by 8 bits.
- R5: When the shifted sum falls outside the 16-bit signed range, `result_o` saturates to 0x7FFF (positive) or 0x8000 (negative).
- R6: A `row_start_i` pulse abandons any partial row, and no result is produced for that row. A step accepted in the same cycle as `row_start_i` is the first step of the new row.
- R7: After a row completes, the next accepted step begins a new row without any `row_start_i`. Steps may arrive on consecutive cycles across row boundaries, or with idle cycles between them.
- R8: A vector write and a step that read the same bank and offset in the same cycle return the value held before the write.
- R9: After reset, `result_valid_o=0`, `result_o=0` and every vector element reads as zero.
- R10: `result_o` holds its value between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vec_we_i | input | 1 | Vector write enable |
| vec_waddr_i | input | clog2(VEC_LEN) | Flat vector write address |
| vec_wdata_i | input | DATA_W | Vector element, Q8.8 |
| row_start_i | input | 1 | Begin a new row, discarding any partial one |
| step_valid_i | input | 1 | One nonzero per bank is presented |
| step_wgt_i | input | N_BANKS*DATA_W | Per-lane weights, lane 0 in the low bits |
| step_idx_i | input | N_BANKS*clog2(VEC_LEN/N_BANKS) | Per-lane bank-internal indices |
| result_o | output | DATA_W | Saturated Q8.8 dot product |
| result_valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
Two functions can coincide in a single cycle. A vector write can land on the very bank word that a step is reading, and a row boundary can meet a new step: `row_start_i` can arrive together with a step, or a step can arrive on the cycle right after the previous row's final step. The bench provokes both with directed sequences, and the random phase also produces them through random writes and zero-gap steps. A reference model computes each step's sum from its own copy of the vector before it applies any write from the same cycle. It then judges the value and the exact arrival cycle of every pulse. Any pulse that the model did not predict is flagged.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  // Address width for a memory of the given depth, never below one bit.
  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth <= 1) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/bbs_vec_bank.sv
module bbs_vec_bank #(
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i && int'(waddr_i) < int'(DEPTH)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // Registered read; a same-cycle write is seen on the following read only.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (int'(raddr_i) < int'(DEPTH)) rdata_o <= mem_q[raddr_i];
    else rdata_o <= '0;
  end

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(waddr_i) < int'(DEPTH)) |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/bbs_adder_tree.sv
module bbs_adder_tree #(
  parameter int unsigned N_IN = 4,
  parameter int unsigned W    = 34
) (
  input  logic signed [W-1:0] in_i [N_IN],
  output logic signed [W-1:0] sum_o
);
  localparam int unsigned LVLS = (N_IN <= 1) ? 0 : $clog2(N_IN);
  localparam int unsigned P    = 1 << LVLS;

  logic signed [W-1:0] node [2*P-1];

  for (genvar i = 0; i < int'(P); i++) begin : g_leaf
    if (i < int'(N_IN)) begin : g_used
      assign node[P-1+i] = in_i[i];
    end else begin : g_pad
      assign node[P-1+i] = '0;
    end
  end

  for (genvar i = 0; i < int'(P) - 1; i++) begin : g_node
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];
endmodule

// File: rtl/bbs_row_ctrl.sv
module bbs_row_ctrl #(
  parameter int unsigned NNZ_PER_BANK = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_start_i,
  input  logic step_valid_i,
  output logic step_first_o,
  output logic step_last_o
);
  localparam int unsigned CNT_W = bbs_pkg::idx_bits(NNZ_PER_BANK + 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign step_first_o = row_start_i | pend_q;
  assign cnt_n        = step_first_o ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign step_last_o  = step_valid_i && (cnt_n == CNT_W'(NNZ_PER_BANK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (step_valid_i) begin
      pend_q <= step_last_o;
      cnt_q  <= step_last_o ? '0 : cnt_n;
    end else if (row_start_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(NNZ_PER_BANK));
  a_r7_auto_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_last_o |=> step_first_o);
endmodule

// File: rtl/bbs_dot_engine.sv
module bbs_dot_engine #(
  parameter int unsigned N_BANKS      = 4,
  parameter int unsigned VEC_LEN      = 12,
  parameter int unsigned NNZ_PER_BANK = 2,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned FRAC_W       = 8,
  parameter int unsigned ACC_W        = 40,
  localparam int unsigned BANK_D = VEC_LEN / N_BANKS,
  localparam int unsigned IDX_W  = bbs_pkg::idx_bits(BANK_D),
  localparam int unsigned ADDR_W = bbs_pkg::idx_bits(VEC_LEN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vec_we_i,
  input  logic [ADDR_W-1:0]         vec_waddr_i,
  input  logic [DATA_W-1:0]         vec_wdata_i,
  input  logic                      row_start_i,
  input  logic                      step_valid_i,
  input  logic [N_BANKS*DATA_W-1:0] step_wgt_i,
  input  logic [N_BANKS*IDX_W-1:0]  step_idx_i,
  output logic [DATA_W-1:0]         result_o,
  output logic                      result_valid_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned PSUM_W = PROD_W + bbs_pkg::idx_bits(N_BANKS) + 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (DATA_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  // ---- row framing
  logic step_first, step_last;

  bbs_row_ctrl #(.NNZ_PER_BANK(NNZ_PER_BANK)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_start_i  (row_start_i),
    .step_valid_i (step_valid_i),
    .step_first_o (step_first),
    .step_last_o  (step_last)
  );

  // ---- per-bank vector memories
  logic [N_BANKS-1:0] bank_hit;
  logic [DATA_W-1:0]  rdata [N_BANKS];

  for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_bank
    localparam int unsigned BASE = b * BANK_D;
    logic [ADDR_W-1:0] rel;
    assign rel         = vec_waddr_i - ADDR_W'(BASE);
    assign bank_hit[b] = vec_we_i && (int'(vec_waddr_i) >= int'(BASE))
                                  && (int'(vec_waddr_i) <  int'(BASE + BANK_D));

    bbs_vec_bank #(.DEPTH(BANK_D), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_hit[b]),
      .waddr_i (IDX_W'(rel)),
      .wdata_i (vec_wdata_i),
      .raddr_i (step_idx_i[b*IDX_W +: IDX_W]),
      .rdata_o (rdata[b])
    );
  end

  // ---- stage 1: weights delayed to meet the memory read
  logic              s1_valid, s1_first, s1_last;
  logic [DATA_W-1:0] s1_wgt [N_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      for (int b = 0; b < int'(N_BANKS); b++) s1_wgt[b] <= '0;
    end else begin
      s1_valid <= step_valid_i;
      s1_first <= step_valid_i && step_first;
      s1_last  <= step_last;
      for (int b = 0; b < int'(N_BANKS); b++) s1_wgt[b] <= step_wgt_i[b*DATA_W +: DATA_W];
    end
  end

  // ---- products and reduction
  logic signed [PSUM_W-1:0] prod [N_BANKS];
  logic signed [PSUM_W-1:0] psum;

  for (genvar b = 0; b < int'(N_BANKS); b++) begin : g_mul
    logic signed [PROD_W-1:0] p;
    assign p       = $signed(s1_wgt[b]) * $signed(rdata[b]);
    assign prod[b] = PSUM_W'(p);
  end

  bbs_adder_tree #(.N_IN(N_BANKS), .W(PSUM_W)) u_tree (
    .in_i  (prod),
    .sum_o (psum)
  );

  // ---- stage 2: registered step sum
  logic                     s2_valid, s2_first, s2_last;
  logic signed [PSUM_W-1:0] s2_psum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_first <= 1'b0;
      s2_last  <= 1'b0;
      s2_psum  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_first <= s1_first;
      s2_last  <= s1_last;
      s2_psum  <= psum;
    end
  end

  // ---- stage 3: accumulate, scale, saturate
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sh;
  logic        [DATA_W-1:0] sat_val;

  assign acc_d  = (s2_first ? '0 : acc_q) + ACC_W'(s2_psum);
  assign acc_sh = acc_d >>> FRAC_W;

  always_comb begin
    if (acc_sh > SAT_HI)      sat_val = SAT_HI[DATA_W-1:0];
    else if (acc_sh < SAT_LO) sat_val = SAT_LO[DATA_W-1:0];
    else                      sat_val = acc_sh[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q          <= '0;
      result_o       <= '0;
      result_valid_o <= 1'b0;
    end else begin
      result_valid_o <= s2_valid && s2_last;
      if (s2_valid) acc_q <= acc_d;
      if (s2_valid && s2_last) result_o <= sat_val;
    end
  end

  a_r1_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit));
  a_r2_weight_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |-> $past(step_valid_i));
  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(step_valid_i, 3));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> $stable(result_o));
endmodule

// File: tb/bbs_dot_engine_bench.sv
module bbs_dot_engine_bench;
  localparam int N  = 4;
  localparam int L  = 12;
  localparam int K  = 2;
  localparam int DW = 16;
  localparam int FW = 8;
  localparam int D  = L / N;
  localparam int IW = bbs_pkg::idx_bits(D);
  localparam int AW = bbs_pkg::idx_bits(L);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic vec_we_i = 1'b0;
  logic [AW-1:0] vec_waddr_i = '0;
  logic [DW-1:0] vec_wdata_i = '0;
  logic row_start_i = 1'b0;
  logic step_valid_i = 1'b0;
  logic [N*DW-1:0] step_wgt_i = '0;
  logic [N*IW-1:0] step_idx_i = '0;
  logic [DW-1:0] result_o;
  logic result_valid_o;

  always #5 clk_i = ~clk_i;

  bbs_dot_engine u_bbs_dot_engine (
    .clk_i, .rst_ni, .vec_we_i, .vec_waddr_i, .vec_wdata_i, .row_start_i,
    .step_valid_i, .step_wgt_i, .step_idx_i, .result_o, .result_valid_o
  );

  int checks = 0, fails = 0, cyc = 0;
  bit running = 0;
  logic signed [DW-1:0] mvec [L];
  longint macc = 0;
  int mcnt = 0;
  bit mfirst = 1;
  logic [DW-1:0] exp_q [1024];
  int due_q [1024];
  int head = 0, tail = 0;
  logic [DW-1:0] last_exp = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [DW-1:0] sat_ref(input longint a);
    longint s = a >>> FW;
    longint hi = (longint'(1) <<< (DW-1)) - 1;
    if (s > hi) return DW'(hi);
    if (s < -hi - 1) return DW'(-hi - 1);
    return DW'(s);
  endfunction

  function automatic logic [N*IW-1:0] pk_idx(input int i0, i1, i2, i3);
    return {IW'(i3), IW'(i2), IW'(i1), IW'(i0)};
  endfunction

  function automatic logic [N*DW-1:0] pk_w(input int w0, w1, w2, w3);
    return {DW'(w3), DW'(w2), DW'(w1), DW'(w0)};
  endfunction

  // One cycle of stimulus; the model reads its vector before applying the write (R8).
  task automatic drive(input bit rs, input bit sv, input logic [N*DW-1:0] w,
                       input logic [N*IW-1:0] ix, input bit we, input int addr,
                       input logic [DW-1:0] data);
    @(negedge clk_i);
    row_start_i = rs; step_valid_i = sv; step_wgt_i = w; step_idx_i = ix;
    vec_we_i = we; vec_waddr_i = AW'(addr); vec_wdata_i = data;
    if (rs) mfirst = 1;
    if (sv) begin
      longint ps = 0;
      for (int b = 0; b < N; b++)
        ps += longint'($signed(w[b*DW +: DW])) * longint'(mvec[b*D + int'(ix[b*IW +: IW])]);
      if (mfirst) begin macc = 0; mcnt = 0; mfirst = 0; end
      macc += ps;
      mcnt++;
      if (mcnt == K) begin
        exp_q[tail] = sat_ref(macc);
        due_q[tail] = cyc + 3;
        tail++;
        mfirst = 1;
      end
    end
    if (we) mvec[addr] = data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, '0, '0, 0, 0, '0);
  endtask

  task automatic wr(input int addr, input int data);
    drive(0, 0, '0, '0, 1, addr, DW'(data));
  endtask

  // Result monitor: value and arrival cycle (R4), no stray pulse (R6), hold (R10)
  always @(negedge clk_i) begin
    if (running) begin
      if (head < tail && due_q[head] == cyc) begin
        chk(result_valid_o == 1'b1, "R4 pulse", longint'(result_valid_o), 1);
        chk(result_o == exp_q[head], "R4/R5 value", longint'($signed(result_o)),
            longint'($signed(exp_q[head])));
        last_exp = exp_q[head];
        head++;
      end else if (result_valid_o) begin
        chk(0, "R6 unexpected result", 1, 0);
      end else if (result_o != last_exp) begin
        chk(0, "R10 hold", longint'($signed(result_o)), longint'($signed(last_exp)));
      end
    end
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) mvec[i] = '0;
    void'($urandom(32'd1234));
    idle(3);
    @(negedge clk_i);
    chk(result_valid_o == 1'b0, "R9 valid after reset", longint'(result_valid_o), 0);
    chk(result_o == '0, "R9 result after reset", longint'(result_o), 0);
    rst_ni = 1'b1;
    running = 1;

    // R9: memories read as zero before any write
    drive(0, 1, pk_w(300, -700, 1000, 5), pk_idx(0, 1, 2, 2), 0, 0, '0);
    drive(0, 1, pk_w(256, 256, 256, 256), pk_idx(1, 0, 0, 1), 0, 0, '0);
    idle(4);

    // R1: load V[i] = (i+1) in Q8.8
    for (int a = 0; a < L; a++) wr(a, (a + 1) * 256);

    // R2/R3: reference pairing, lanes pick V0,V3,V7,V9 then V2,V4,V8,V11
    drive(1, 1, pk_w(256, -128, 512, 64), pk_idx(0, 0, 1, 0), 0, 0, '0);
    drive(0, 1, pk_w(-256, 384, 32, -1024), pk_idx(2, 1, 2, 2), 0, 0, '0);
    idle(4);

    // R5: positive and negative saturation
    for (int a = 0; a < L; a++) wr(a, 16'h7fff);
    drive(0, 1, pk_w(32767, 32767, 32767, 32767), pk_idx(0, 1, 2, 0), 0, 0, '0);
    drive(0, 1, pk_w(32767, 32767, 32767, 32767), pk_idx(1, 2, 0, 1), 0, 0, '0);
    drive(0, 1, pk_w(-32768, -32768, -32768, -32768), pk_idx(0, 0, 0, 0), 0, 0, '0);
    drive(0, 1, pk_w(-32768, -32768, -32768, -32768), pk_idx(2, 2, 2, 2), 0, 0, '0);
    idle(4);
    for (int a = 0; a < L; a++) wr(a, (a * 37) - 200);

    // R6: row_start alone abandons a partial row
    drive(0, 1, pk_w(900, 900, 900, 900), pk_idx(0, 0, 0, 0), 0, 0, '0);
    drive(1, 0, '0, '0, 0, 0, '0);
    drive(0, 1, pk_w(100, 200, 300, 400), pk_idx(1, 1, 1, 1), 0, 0, '0);
    drive(0, 1, pk_w(-50, 60, -70, 80), pk_idx(2, 0, 2, 0), 0, 0, '0);
    // R6: row_start together with a step mid-row
    drive(0, 1, pk_w(777, 777, 777, 777), pk_idx(2, 2, 2, 2), 0, 0, '0);
    drive(1, 1, pk_w(10, 20, 30, 40), pk_idx(0, 1, 2, 0), 0, 0, '0);
    drive(0, 1, pk_w(-11, 22, -33, 44), pk_idx(1, 2, 0, 1), 0, 0, '0);
    // R7: back-to-back rows with no row_start and no gap
    drive(0, 1, pk_w(256, 256, 256, 256), pk_idx(0, 0, 0, 0), 0, 0, '0);
    drive(0, 1, pk_w(512, 512, 512, 512), pk_idx(1, 1, 1, 1), 0, 0, '0);
    idle(4);

    // R8: write and read the same word in one cycle, then read it again
    drive(0, 1, pk_w(256, 256, 256, 256), pk_idx(0, 1, 0, 0), 1, 4, DW'(5000));
    drive(0, 1, pk_w(0, 0, 0, 0), pk_idx(0, 0, 0, 0), 0, 0, '0);
    drive(0, 1, pk_w(0, 256, 0, 0), pk_idx(0, 1, 0, 0), 0, 0, '0);
    drive(0, 1, pk_w(0, 0, 0, 0), pk_idx(0, 0, 0, 0), 0, 0, '0);
    idle(4);

    // Random rows with gaps, writes and optional row_start
    for (int r = 0; r < 60; r++) begin
      for (int s = 0; s < K; s++) begin
        logic [N*DW-1:0] w;
        logic [N*IW-1:0] ix;
        bit rs, we;
        for (int b = 0; b < N; b++) begin
          w[b*DW +: DW]  = DW'($urandom);
          ix[b*IW +: IW] = IW'($urandom_range(0, D - 1));
        end
        rs = (s == 0) && ($urandom_range(0, 1) == 1);
        we = ($urandom_range(0, 3) == 0);
        drive(rs, 1, w, ix, we, $urandom_range(0, L - 1), DW'($urandom));
        if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 2));
      end
    end
    idle(6);
    chk(head == tail, "R4 all results seen", longint'(head), longint'(tail));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule